// File: doc/BRIEF.md
# Equality-Compare Event Timer

This block is a register-mapped event timer. It has one free-running 32-bit main counter and one comparator channel. The main counter advances once for each pulse on a tick-enable input, so it can run slower than the bus clock. The channel raises an interrupt when the counter value it samples on a tick equals the live comparator exactly. A value that the counter has already passed is only matched again after the counter wraps all the way round.

Software writes to the comparator do not reach the live comparator at once. They are held in a staging register, which is copied across on the second counter tick after the write. A read of the comparator address completes any pending copy in the same cycle. Software therefore reads back the comparator after writing it, so that the comparison it makes next is valid.

The channel runs in one-shot or periodic mode. In periodic mode a set-value bit marks the next comparator write as the start point. The write after that loads the period that is added to the comparator on every match. The interrupt is either a one-cycle pulse or a level that is held until software clears the status flag.

Top module: `evt_timer`

Word addresses: 0 general config (bit 0 run), 1 status (bit 0 channel flag, write 1 to clear), 2 counter, 3 counter upper half (reads zero, writes ignored), 4 channel config, 5 comparator.

## Requirements
- R1: While general-config bit 0 is 1, each cycle with tick_i high increments the counter by one, and 0xFFFFFFFF wraps to 0. While bit 0 is 0, the counter holds its value.
- R2: A write to address 2 loads the counter only while bit 0 of the general config is 0. A write to address 2 while the counter runs is ignored. Address 3 always reads 0.
- R3: A comparator write (address 5) without a readback reaches the live comparator on the second tick after the write. The comparison made on that tick still uses the old value, so writing counter+1 is missed and writing counter+2 fires on the third tick.
- R4: A read of address 5 returns the value most recently written and copies any pending staged value into the live comparator in that cycle. After a write of counter+d followed by a read, the match occurs on tick d+1.
- R5: A match needs strict equality. A comparator value behind the counter gives no interrupt until the counter wraps.
- R6: With channel-config bit 0 (level) clear, each match gives an irq_o pulse of exactly one clock and sets status bit 0.
- R7: With the level bit set, irq_o follows status bit 0. The bit stays set until a status write with bit 0 = 1, and a write of 0 leaves it set.
- R8: With channel-config bit 2 (periodic) set, each match adds the stored period to the comparator, so the channel fires every period ticks.
- R9: With channel-config bit 3 (set-value) set, the next comparator write goes to the comparator, and bit 3 then reads 0. In periodic mode, the next comparator write with bit 3 clear loads the period.
- R10: In one-shot mode (bit 2 clear), the comparator keeps its value after a match and no second interrupt follows before a wrap.
- R11: With channel-config bit 1 (enable) clear, comparator writes are still captured, but no match fires and status does not set. After the bit is set, matches fire normally.
- R12: After reset, all registers read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter tick enable, one clock per tick |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Channel interrupt, pulse or level |

## Verification
The assertions assume that a tick and a bus access to the comparator never occur in the same clock. They also assume that the channel is not set to a periodic period of zero or one while ticks arrive on back-to-back clocks. The stimulus keeps within these limits. Each tick lasts one clock and is separated from every bus access by at least one clock, and periods are drawn at random between 3 and 9. Random tick bursts and random counter stops test counting against a bench model of the counter. Directed offsets (behind, +1, +2, with and without readback) test the staging window.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [2:0] {
    A_GCFG   = 3'd0,
    A_STAT   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CHCFG  = 3'd4,
    A_CMP    = 3'd5
  } reg_addr_e;

  // channel config, bit 0 upward: level, enable, periodic, set-value, 32-bit mode
  typedef struct packed {
    logic m32;
    logic setv;
    logic per;
    logic en;
    logic level;
  } ch_cfg_t;

  localparam int unsigned CH_CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i && wr_i)  cnt_q <= wdata_i;
    else if (run_i && tick_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i |=> cnt_q == $past(cnt_q) + CW'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !wr_i |=> $stable(cnt_q)); // R1
  AST_CNT_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage #(
  parameter int unsigned CW         = 32,
  parameter int unsigned XFER_TICKS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          force_i,
  input  logic          tick_i,
  output logic          xfer_o,
  output logic          pending_o,
  output logic [CW-1:0] stage_o
);
  localparam int unsigned TW = $clog2(XFER_TICKS + 1);

  logic [CW-1:0] stage_q;
  logic          pending_q;
  logic [TW-1:0] tcnt_q;
  logic          last_tick;

  assign last_tick = tick_i && (tcnt_q == TW'(XFER_TICKS - 1));
  assign xfer_o    = pending_q && !load_i && (force_i || last_tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      pending_q <= 1'b0;
      tcnt_q    <= '0;
    end else if (load_i) begin
      stage_q   <= wdata_i;
      pending_q <= 1'b1;
      tcnt_q    <= '0;
    end else if (xfer_o) begin
      pending_q <= 1'b0;
      tcnt_q    <= '0;
    end else if (pending_q && tick_i) begin
      tcnt_q    <= tcnt_q + TW'(1);
    end
  end

  assign pending_o = pending_q;
  assign stage_o   = stage_q;

  AST_RD_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i && !load_i |=> !pending_q); // R4
  AST_XFER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> tcnt_q < TW'(XFER_TICKS)); // R3
  AST_LOAD_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pending_q && stage_q == $past(wdata_i)); // R3
endmodule

// File: rtl/evt_channel.sv
module evt_channel #(
  parameter int unsigned CW         = 32,
  parameter int unsigned XFER_TICKS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          per_i,
  input  logic          setv_i,
  input  logic          level_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cmp_wr_i,
  input  logic          cmp_rd_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          stat_clr_i,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic [CW-1:0] cmp_q, period_q, stage;
  logic          flag_q, pulse_q;
  logic          stage_load, per_load, xfer, pending, hit;

  assign stage_load = cmp_wr_i && (setv_i || !per_i);
  assign per_load   = cmp_wr_i && !setv_i && per_i;

  cmp_stage #(.CW(CW), .XFER_TICKS(XFER_TICKS)) i_cmp_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (stage_load),
    .wdata_i   (wdata_i),
    .force_i   (cmp_rd_i),
    .tick_i    (tick_i),
    .xfer_o    (xfer),
    .pending_o (pending),
    .stage_o   (stage)
  );

  assign hit = en_i && run_i && tick_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q    <= '0;
      period_q <= '0;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (xfer)              cmp_q <= stage;
      else if (hit && per_i) cmp_q <= cmp_q + period_q;
      if (per_load) period_q <= wdata_i;
      if (hit)             flag_q <= 1'b1;
      else if (stat_clr_i) flag_q <= 1'b0;
      pulse_q <= hit;
    end
  end

  assign cmp_o  = pending ? stage : cmp_q;
  assign flag_o = flag_q;
  assign irq_o  = level_i ? flag_q : pulse_q;

  AST_PERIOD_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && per_i && !xfer |=> cmp_q == $past(cmp_q) + $past(period_q)); // R8
  AST_ONESHOT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !per_i && !xfer |=> $stable(cmp_q)); // R10
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && flag_q && !stat_clr_i |=> flag_q); // R7
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_q); // R11
  AST_EDGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !pulse_q); // R6
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned XFER_TICKS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  logic          run_q;
  ch_cfg_t       cfg_q;
  logic [DW-1:0] cnt, cmp_rd;
  logic          flag;
  logic          wr, rd;
  logic          wr_gcfg, wr_stat, wr_cnt, wr_chcfg, wr_cmp, rd_cmp;

  assign wr = bus_sel_i && bus_we_i;
  assign rd = bus_sel_i && !bus_we_i;

  assign wr_gcfg  = wr && bus_addr_i == A_GCFG;
  assign wr_stat  = wr && bus_addr_i == A_STAT;
  assign wr_cnt   = wr && bus_addr_i == A_CNT_LO;
  assign wr_chcfg = wr && bus_addr_i == A_CHCFG;
  assign wr_cmp   = wr && bus_addr_i == A_CMP;
  assign rd_cmp   = rd && bus_addr_i == A_CMP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (wr_gcfg) run_q <= bus_wdata_i[0];
      if (wr_chcfg)                 cfg_q      <= ch_cfg_t'(bus_wdata_i[CH_CFG_W-1:0]);
      else if (wr_cmp && cfg_q.setv) cfg_q.setv <= 1'b0;
    end
  end

  evt_counter #(.CW(DW)) i_evt_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick_i),
    .wr_i    (wr_cnt),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt)
  );

  evt_channel #(.CW(DW), .XFER_TICKS(XFER_TICKS)) i_evt_channel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_q.en),
    .per_i      (cfg_q.per),
    .setv_i     (cfg_q.setv),
    .level_i    (cfg_q.level),
    .run_i      (run_q),
    .tick_i     (tick_i),
    .cnt_i      (cnt),
    .cmp_wr_i   (wr_cmp),
    .cmp_rd_i   (rd_cmp),
    .wdata_i    (bus_wdata_i),
    .stat_clr_i (wr_stat && bus_wdata_i[0]),
    .cmp_o      (cmp_rd),
    .flag_o     (flag),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_GCFG:   bus_rdata_o[0] = run_q;
      A_STAT:   bus_rdata_o[0] = flag;
      A_CNT_LO: bus_rdata_o = cnt;
      A_CHCFG:  bus_rdata_o[CH_CFG_W-1:0] = cfg_q;
      A_CMP:    bus_rdata_o = cmp_rd;
      default:  bus_rdata_o = '0;
    endcase
  end

  AST_SETV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp && cfg_q.setv |=> !cfg_q.setv); // R9
  AST_RST_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.level && !tick_i |=> !irq_o); // R12
endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;
  localparam logic [2:0] GCFG = 3'd0, STAT = 3'd1, CNT = 3'd2, CNTH = 3'd3,
                         CHCFG = 3'd4, CMP = 3'd5;
  localparam logic [31:0] C_LEVEL = 32'h1, C_EN = 32'h2, C_PER = 32'h4, C_SETV = 32'h8;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] cnt_m = '0;
  bit run_m = 0;

  always #4 clk_i = ~clk_i;

  evt_timer i_evt_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic tk(output bit f);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    f = irq_o;
    if (run_m) cnt_m = cnt_m + 32'd1;
  endtask

  task automatic run_ticks(input int n, output int first, output int nf);
    bit f;
    first = 0; nf = 0;
    for (int i = 1; i <= n; i++) begin
      tk(f);
      if (f) begin nf++; if (first == 0) first = i; end
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin : main
    logic [31:0] d, c, nxt, per;
    int first, nf, bad;
    bit f, e;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 reset state
    brd(GCFG, d);  chk(d == 0, "R12 gcfg", d, 0);
    brd(STAT, d);  chk(d == 0, "R12 stat", d, 0);
    brd(CNT, d);   chk(d == 0, "R12 cnt", d, 0);
    brd(CHCFG, d); chk(d == 0, "R12 chcfg", d, 0);
    brd(CMP, d);   chk(d == 0, "R12 cmp", d, 0);
    chk(irq_o == 1'b0, "R12 irq", 32'(irq_o), 0);

    // R1 random bursts with stops
    bwr(GCFG, 32'h1); run_m = 1;
    for (int i = 0; i < 30; i++) begin
      repeat ($urandom_range(1, 6)) tk(f);
      if ($urandom_range(0, 3) == 0) begin
        bwr(GCFG, 0); run_m = 0;
        repeat ($urandom_range(1, 3)) tk(f);
      end
      brd(CNT, d); chk(d == cnt_m, "R1 count", d, cnt_m);
      if (!run_m) begin bwr(GCFG, 32'h1); run_m = 1; end
    end

    // R2 load while stopped, R1 wrap
    bwr(GCFG, 0); run_m = 0;
    bwr(CNT, 32'hFFFF_FFFE); cnt_m = 32'hFFFF_FFFE;
    brd(CNT, d); chk(d == cnt_m, "R2 load stopped", d, cnt_m);
    bwr(GCFG, 32'h1); run_m = 1;
    tk(f); tk(f);
    brd(CNT, d); chk(d == 0, "R1 wrap", d, 0);
    bwr(CNT, 32'h1234);
    brd(CNT, d); chk(d == cnt_m, "R2 ignored running", d, cnt_m);
    brd(CNTH, d); chk(d == 0, "R2 high half", d, 0);

    // R6 edge one-shot, R10
    bwr(GCFG, 0); run_m = 0; bwr(CNT, 0); cnt_m = 0; bwr(GCFG, 1); run_m = 1;
    bwr(CHCFG, C_EN);
    bwr(CMP, 32'd10);
    brd(CMP, d); chk(d == 32'd10, "R4 readback", d, 10);
    repeat (10) tk(f);
    tk(f); chk(f == 1'b1, "R6 fire", 32'(f), 1);
    @(negedge clk_i); chk(irq_o == 1'b0, "R6 one cycle", 32'(irq_o), 0);
    brd(STAT, d); chk(d == 1, "R6 status", d, 1);
    bwr(STAT, 1);
    brd(STAT, d); chk(d == 0, "R6 status clear", d, 0);
    brd(CMP, d); chk(d == 32'd10, "R10 cmp kept", d, 10);
    run_ticks(20, first, nf); chk(nf == 0, "R10 no refire", 32'(nf), 0);

    // R5 comparator behind counter
    c = cnt_m; bwr(CMP, c - 32'd5); brd(CMP, d);
    run_ticks(30, first, nf); chk(nf == 0, "R5 behind", 32'(nf), 0);

    // R3 staging window
    c = cnt_m; bwr(CMP, c + 32'd1);
    run_ticks(30, first, nf); chk(nf == 0, "R3 missed +1", 32'(nf), 0);
    c = cnt_m; bwr(CMP, c + 32'd2);
    run_ticks(6, first, nf); chk(first == 3 && nf == 1, "R3 +2 tick", 32'(first), 3);

    // R4 forced transfer
    c = cnt_m; bwr(CMP, c + 32'd1);
    brd(CMP, d); chk(d == c + 32'd1, "R4 read value", d, c + 32'd1);
    run_ticks(6, first, nf); chk(first == 2 && nf == 1, "R4 tick", 32'(first), 2);

    // R7 level mode
    bwr(STAT, 1);
    bwr(CHCFG, C_EN | C_LEVEL);
    c = cnt_m; bwr(CMP, c + 32'd3); brd(CMP, d);
    run_ticks(4, first, nf); chk(first == 4, "R7 fire", 32'(first), 4);
    repeat (3) @(negedge clk_i);
    chk(irq_o == 1'b1, "R7 held", 32'(irq_o), 1);
    bwr(STAT, 0); chk(irq_o == 1'b1, "R7 write0", 32'(irq_o), 1);
    bwr(STAT, 1); chk(irq_o == 1'b0, "R7 cleared", 32'(irq_o), 0);

    // R8/R9 periodic with random periods
    for (int r = 0; r < 3; r++) begin
      per = $urandom_range(3, 9);
      bwr(CHCFG, C_EN | C_PER | C_SETV);
      c = cnt_m; bwr(CMP, c + 32'd4);
      brd(CHCFG, d); chk(d == (C_EN | C_PER), "R9 setv self clear", d, C_EN | C_PER);
      bwr(CMP, per);
      brd(CMP, d); chk(d == c + 32'd4, "R9 start kept", d, c + 32'd4);
      nxt = c + 32'd4; bad = 0;
      for (int i = 0; i < 40; i++) begin
        e = (cnt_m == nxt);
        tk(f);
        if (f != e) bad++;
        if (e) nxt = nxt + per;
      end
      chk(bad == 0, "R8 periodic fires", 32'(bad), 0);
      brd(CMP, d); chk(d == nxt, "R8 cmp advanced", d, nxt);
    end

    // R11 disabled channel
    bwr(CHCFG, 0); bwr(STAT, 1);
    c = cnt_m; bwr(CMP, c + 32'd3);
    brd(CMP, d); chk(d == c + 32'd3, "R11 captured", d, c + 32'd3);
    run_ticks(10, first, nf); chk(nf == 0, "R11 no irq", 32'(nf), 0);
    brd(STAT, d); chk(d == 0, "R11 no status", d, 0);
    c = cnt_m; bwr(CMP, c + 32'd5); brd(CMP, d);
    bwr(CHCFG, C_EN);
    run_ticks(8, first, nf); chk(first == 6 && nf == 1, "R11 enabled fires", 32'(first), 6);

    done = 1;
    report();
  end
endmodule